// File: doc/BRIEF.md
# Tiled Background Pixel Generator

This block turns one scrollable background plane built from 8x8 tiles into a stream of pixels for a single scanline. The plane is a grid of 16-bit tile descriptors held in a name table. Each descriptor selects a pattern in a byte-addressed graphics memory, where every pattern row is four bytes at four bits per pixel. The descriptor also carries the mirroring, colour-table and depth settings for that tile. For every screen pixel the block delivers a 6-bit colour index, a priority bit and a transparent flag. The index is the 2-bit colour table in the upper bits and the 4-bit pixel value in the lower bits.

A line begins when `line_start` is pulsed with the line number and both scroll offsets. The block fetches tiles from left to right. Each tile takes two single-cycle-latency memory reads: a descriptor read, then a 32-bit pattern-row read. Descriptor and row for the next tile are fetched while the current tile is being shifted out. Once the first pixel appears, the line is delivered at one pixel per clock with no gaps. Both memories are plain synchronous read ports: an address presented with its read strobe returns data in the following cycle.

Top module: `tpg_plane`

## Requirements
- R1: During and right after reset, `pix_valid`, `nt_rd` and `pat_rd` are low, and no memory read is issued until a `line_start` pulse arrives.
- R2: Descriptor layout: bits [10:0] tile index, bit 11 horizontal mirror, bit 12 vertical mirror, bits [14:13] colour table, bit 15 priority. `pix_color[5:4]` equals the colour table and `pix_prio` equals bit 15 of the descriptor of the tile the pixel comes from.
- R3: `pix_transp` is high exactly when the 4-bit pixel value (`pix_color[3:0]`) is 0, for every colour table.
- R4: The pattern row is read at byte address index*32 + r*4, where r is the row inside the tile, replaced by 7-r when the vertical mirror bit is set. `pat_data[31:24]` is the byte at that address, and the following bytes come next in descending bit order. Inside each byte the high nibble is the left pixel. A pattern read always follows a descriptor read in the preceding cycle.
- R5: With the horizontal mirror bit set, the eight pixels of a tile row come out in reverse order.
- R6: Screen pixel x shows plane column (x + scroll_x) mod 512. The plane is 64 tiles wide and wraps. The descriptor is read at word address tile_row*64 + tile_col.
- R7: Screen line y shows plane row (y + scroll_y) mod (8*MAP_H), so the plane wraps vertically.
- R8: After `line_start`, exactly LINE_W pixels are delivered. Once the first pixel is out, `pix_valid` stays high every cycle until the last one, and then stays low.
- R9: A `line_start` during a line abandons it. `pix_valid` is low in the next cycle, and every pixel delivered afterwards belongs to the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that begins a scanline |
| line_y | input | VY_W | Screen line number |
| scroll_x | input | VX_W | Horizontal scroll offset in pixels |
| scroll_y | input | VY_W | Vertical scroll offset in pixels |
| nt_rd | output | 1 | Name-table read strobe |
| nt_addr | output | NT_AW | Name-table word address |
| nt_data | input | 16 | Descriptor returned one cycle after `nt_rd` |
| pat_rd | output | 1 | Pattern read strobe |
| pat_addr | output | 16 | Pattern byte address, 4-byte aligned |
| pat_data | input | 32 | Four pattern bytes returned one cycle after `pat_rd` |
| pix_valid | output | 1 | Pixel outputs carry a pixel this cycle |
| pix_color | output | 6 | Colour table (5:4) and pixel value (3:0) |
| pix_prio | output | 1 | Depth/priority bit of the tile |
| pix_transp | output | 1 | Pixel value is zero |

## Verification
Two events can fall in the same cycle. The last pixel of one tile can be shifted out while the next tile is taken from the prefetch slot, and the fetcher refills the slot shortly afterwards. The hardest case is a fine scroll of 7, where the first tile yields a single pixel before the handoff. Sweeping every horizontal offset from 0 to 511 exercises every handoff position, and the bench checks that the pixels stay gap-free and match an arithmetic model. The other collision is a new `line_start` arriving while pixels of the old line are emerging. This is provoked mid-line and judged by requiring exactly LINE_W pixels, all belonging to the new line.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int DESC_W = 16;
  localparam int ROW_W  = 32;
  localparam int IDX_W  = 11;
  localparam int PAT_AW = IDX_W + 5;

  typedef struct packed {
    logic             prio;
    logic [1:0]       pal;
    logic             vflip;
    logic             hflip;
    logic [IDX_W-1:0] idx;
  } tile_desc_t;

  // Reverse the order of the eight 4-bit pixels in a row.
  function automatic logic [ROW_W-1:0] mirror_row(input logic [ROW_W-1:0] r);
    logic [ROW_W-1:0] o;
    for (int i = 0; i < 8; i++) begin
      o[4*i +: 4] = r[4*(7-i) +: 4];
    end
    return o;
  endfunction

  // Byte address of one pattern row: index*32 + row*4, row mirrored on vflip.
  function automatic logic [PAT_AW-1:0] row_address(input logic [IDX_W-1:0] idx,
                                                     input logic [2:0] row,
                                                     input logic vflip);
    logic [2:0] r;
    r = vflip ? ~row : row;
    return {idx, r, 2'b00};
  endfunction

  // Drop the first fx pixels of a row (left pixel sits in the top nibble).
  function automatic logic [ROW_W-1:0] skip_pixels(input logic [ROW_W-1:0] r,
                                                    input logic [2:0] fx);
    return r << {fx, 2'b00};
  endfunction

  // Number of pixels left in the first tile of a line.
  function automatic logic [3:0] first_count(input logic [2:0] fx);
    return 4'd8 - {1'b0, fx};
  endfunction

endpackage

// File: rtl/tpg_fetch.sv
module tpg_fetch
  import tpg_pkg::*;
#(
  parameter int TX_W = 6,
  parameter int TY_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [TX_W-1:0]      tx0,
  input  logic [TY_W-1:0]      ty0,
  input  logic [2:0]           fy0,
  input  logic                 want,
  input  logic                 take,
  output logic                 nt_rd,
  output logic [TY_W+TX_W-1:0] nt_addr,
  input  logic [DESC_W-1:0]    nt_data,
  output logic                 pat_rd,
  output logic [PAT_AW-1:0]    pat_addr,
  input  logic [ROW_W-1:0]     pat_data,
  output logic                 slot_full,
  output logic [ROW_W-1:0]     slot_row,
  output logic [1:0]           slot_pal,
  output logic                 slot_prio
);

  typedef enum logic [1:0] {F_IDLE, F_NAME, F_PATT, F_CATCH} fstate_t;

  fstate_t     state;
  logic [TX_W-1:0] col;
  logic [TY_W-1:0] trow;
  logic [2:0]  frow;
  logic        hold_hflip;
  logic [1:0]  hold_pal;
  logic        hold_prio;
  tile_desc_t  desc;

  assign desc     = tile_desc_t'(nt_data);
  assign nt_rd    = (state == F_NAME);
  assign nt_addr  = {trow, col};
  assign pat_rd   = (state == F_PATT);
  assign pat_addr = row_address(desc.idx, frow, desc.vflip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= F_IDLE;
      col        <= '0;
      trow       <= '0;
      frow       <= '0;
      hold_hflip <= 1'b0;
      hold_pal   <= '0;
      hold_prio  <= 1'b0;
      slot_full  <= 1'b0;
      slot_row   <= '0;
      slot_pal   <= '0;
      slot_prio  <= 1'b0;
    end else if (start) begin
      state     <= F_IDLE;
      col       <= tx0;
      trow      <= ty0;
      frow      <= fy0;
      slot_full <= 1'b0;
    end else begin
      unique case (state)
        F_IDLE:  if (want && !slot_full) state <= F_NAME;
        F_NAME:  state <= F_PATT;
        F_PATT: begin
          hold_hflip <= desc.hflip;
          hold_pal   <= desc.pal;
          hold_prio  <= desc.prio;
          col        <= col + 1'b1;
          state      <= F_CATCH;
        end
        F_CATCH: begin
          slot_row  <= hold_hflip ? mirror_row(pat_data) : pat_data;
          slot_pal  <= hold_pal;
          slot_prio <= hold_prio;
          state     <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
      if (state == F_CATCH)  slot_full <= 1'b1;
      else if (take)         slot_full <= 1'b0;
    end
  end

endmodule

// File: rtl/tpg_shift.sv
module tpg_shift
  import tpg_pkg::*;
#(
  parameter int LINE_W = 320,
  parameter int CNT_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       fx0,
  input  logic             slot_full,
  input  logic [ROW_W-1:0] slot_row,
  input  logic [1:0]       slot_pal,
  input  logic             slot_prio,
  output logic             take,
  output logic             want,
  output logic             pix_valid,
  output logic [5:0]       pix_color,
  output logic             pix_prio,
  output logic             pix_transp,
  output logic             pix_last
);

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(LINE_W);

  logic [ROW_W-1:0] cur_row;
  logic [1:0]       cur_pal;
  logic             cur_prio;
  logic [3:0]       cur_cnt;
  logic [2:0]       fx;
  logic             first;
  logic             running;
  logic [CNT_W-1:0] remaining;
  logic             emit;
  logic             need_load;

  assign want      = (remaining != '0);
  assign emit      = running && (cur_cnt != 4'd0) && want;
  assign need_load = (cur_cnt == 4'd0) || (emit && cur_cnt == 4'd1);
  assign take      = need_load && slot_full && want && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_row    <= '0;
      cur_pal    <= '0;
      cur_prio   <= 1'b0;
      cur_cnt    <= '0;
      fx         <= '0;
      first      <= 1'b0;
      running    <= 1'b0;
      remaining  <= '0;
      pix_valid  <= 1'b0;
      pix_color  <= '0;
      pix_prio   <= 1'b0;
      pix_transp <= 1'b0;
      pix_last   <= 1'b0;
    end else if (start) begin
      cur_cnt   <= '0;
      fx        <= fx0;
      first     <= 1'b1;
      running   <= 1'b0;
      remaining <= TOTAL;
      pix_valid <= 1'b0;
      pix_last  <= 1'b0;
    end else begin
      pix_valid  <= emit;
      pix_color  <= {cur_pal, cur_row[ROW_W-1 -: 4]};
      pix_prio   <= cur_prio;
      pix_transp <= (cur_row[ROW_W-1 -: 4] == 4'd0);
      pix_last   <= emit && (remaining == ONE);
      if (emit) remaining <= remaining - ONE;
      if (!running && cur_cnt != 4'd0 && slot_full) running <= 1'b1;
      if (take) begin
        cur_row  <= first ? skip_pixels(slot_row, fx) : slot_row;
        cur_cnt  <= first ? first_count(fx) : 4'd8;
        cur_pal  <= slot_pal;
        cur_prio <= slot_prio;
        first    <= 1'b0;
      end else if (emit) begin
        cur_row <= cur_row << 4;
        cur_cnt <= cur_cnt - 4'd1;
      end
    end
  end

endmodule

// File: rtl/tpg_plane.sv
module tpg_plane
  import tpg_pkg::*;
#(
  parameter int LINE_W = 320,
  parameter int MAP_W  = 64,
  parameter int MAP_H  = 32,
  localparam int TX_W  = $clog2(MAP_W),
  localparam int TY_W  = $clog2(MAP_H),
  localparam int VX_W  = TX_W + 3,
  localparam int VY_W  = TY_W + 3,
  localparam int NT_AW = TX_W + TY_W,
  localparam int CNT_W = $clog2(LINE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [VY_W-1:0]   line_y,
  input  logic [VX_W-1:0]   scroll_x,
  input  logic [VY_W-1:0]   scroll_y,
  output logic              nt_rd,
  output logic [NT_AW-1:0]  nt_addr,
  input  logic [15:0]       nt_data,
  output logic              pat_rd,
  output logic [15:0]       pat_addr,
  input  logic [31:0]       pat_data,
  output logic              pix_valid,
  output logic [5:0]        pix_color,
  output logic              pix_prio,
  output logic              pix_transp
);

  logic [VY_W-1:0]  plane_y;
  logic             want;
  logic             take;
  logic             slot_full;
  logic [ROW_W-1:0] slot_row;
  logic [1:0]       slot_pal;
  logic             slot_prio;
  logic             pix_last;

  // Plane row wraps modulo the plane height by width truncation.
  assign plane_y = line_y + scroll_y;

  tpg_fetch #(.TX_W(TX_W), .TY_W(TY_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (line_start),
    .tx0       (scroll_x[VX_W-1:3]),
    .ty0       (plane_y[VY_W-1:3]),
    .fy0       (plane_y[2:0]),
    .want      (want),
    .take      (take),
    .nt_rd     (nt_rd),
    .nt_addr   (nt_addr),
    .nt_data   (nt_data),
    .pat_rd    (pat_rd),
    .pat_addr  (pat_addr),
    .pat_data  (pat_data),
    .slot_full (slot_full),
    .slot_row  (slot_row),
    .slot_pal  (slot_pal),
    .slot_prio (slot_prio)
  );

  tpg_shift #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (line_start),
    .fx0        (scroll_x[2:0]),
    .slot_full  (slot_full),
    .slot_row   (slot_row),
    .slot_pal   (slot_pal),
    .slot_prio  (slot_prio),
    .take       (take),
    .want       (want),
    .pix_valid  (pix_valid),
    .pix_color  (pix_color),
    .pix_prio   (pix_prio),
    .pix_transp (pix_transp),
    .pix_last   (pix_last)
  );

endmodule

// File: rtl/tpg_plane_chk.sv
module tpg_plane_chk #(
  parameter int LINE_W = 320,
  localparam int CNT_W = $clog2(LINE_W + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       nt_rd,
  input logic       pat_rd,
  input logic       pix_valid,
  input logic [5:0] pix_color,
  input logic       pix_transp,
  input logic       pix_last
);

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) seen <= '0;
    else if (pix_valid)       seen <= seen + CNT_W'(1);
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!pix_valid && !nt_rd && !pat_rd));

  a_r3_transparent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_transp == (pix_color[3:0] == 4'd0)));

  a_r4_name_before_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd |-> $past(nt_rd));

  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_last && !line_start) |=> pix_valid);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= CNT_W'(LINE_W));

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !pix_valid);

endmodule

bind tpg_plane tpg_plane_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/tpg_plane_test.sv
module tpg_plane_test;

  localparam int LW    = 64;
  localparam int MW    = 64;
  localparam int MH    = 4;
  localparam int VXW   = 9;
  localparam int VYW   = 5;
  localparam int NTAW  = 8;
  localparam int PH    = MH * 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_start = 1'b0;
  logic [VYW-1:0]  line_y = '0;
  logic [VXW-1:0]  scroll_x = '0;
  logic [VYW-1:0]  scroll_y = '0;
  logic            nt_rd;
  logic [NTAW-1:0] nt_addr;
  logic [15:0]     nt_data = '0;
  logic            pat_rd;
  logic [15:0]     pat_addr;
  logic [31:0]     pat_data = '0;
  logic            pix_valid;
  logic [5:0]      pix_color;
  logic            pix_prio;
  logic            pix_transp;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  tpg_plane #(.LINE_W(LW), .MAP_W(MW), .MAP_H(MH)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .nt_rd(nt_rd), .nt_addr(nt_addr),
    .nt_data(nt_data), .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data),
    .pix_valid(pix_valid), .pix_color(pix_color), .pix_prio(pix_prio),
    .pix_transp(pix_transp)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] desc_at(input int a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 ^ (32'(a) << 9) ^ 32'h00005a3c;
    return t[15:0] ^ t[31:16];
  endfunction

  function automatic logic [7:0] byte_at(input int a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E3779B1;
    return t[23:16] ^ t[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (nt_rd)  nt_data <= desc_at(int'(nt_addr));
    if (pat_rd) pat_data <= {byte_at(int'(pat_addr)), byte_at(int'(pat_addr) + 1),
                             byte_at(int'(pat_addr) + 2), byte_at(int'(pat_addr) + 3)};
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R8: actual=%0d cycles expected=below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input int x, input int sx, input int y, input int sy,
                       output logic [5:0] col, output logic pr, output logic tr);
    int vx, vy, cx, ry, ba;
    logic [15:0] d;
    logic [7:0] b;
    logic [3:0] nib;
    vx = (x + sx) % 512;
    vy = (y + sy) % PH;
    d  = desc_at((vy / 8) * 64 + vx / 8);
    cx = vx % 8;
    ry = vy % 8;
    if (d[11]) cx = 7 - cx;
    if (d[12]) ry = 7 - ry;
    ba  = int'(d[10:0]) * 32 + ry * 4 + cx / 2;
    b   = byte_at(ba);
    nib = (cx % 2 == 0) ? b[7:4] : b[3:0];
    col = {d[14:13], nib};
    pr  = d[15];
    tr  = (nib == 4'd0);
  endtask

  task automatic start_line(input int y, input int sx, input int sy);
    @(negedge clk);
    line_y     = VYW'(y);
    scroll_x   = VXW'(sx);
    scroll_y   = VYW'(sy);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic collect(input int y, input int sx, input int sy);
    logic [5:0] ec;
    logic ep, et;
    int wait_n;
    bit gap;
    wait_n = 0;
    while (!pix_valid && wait_n < 40) begin
      @(negedge clk);
      wait_n++;
    end
    check(pix_valid, "R8 first pixel", int'(pix_valid), 1);
    gap = 1'b0;
    for (int x = 0; x < LW && !gap; x++) begin
      if (!pix_valid) begin
        check(1'b0, "R8 contiguous", x, LW);
        gap = 1'b1;
      end else begin
        model(x, sx, y, sy, ec, ep, et);
        // R4 R5 R6 R7 colour index, R2 palette bits
        check(pix_color == ec, "R2 R4 R5 R6 R7 colour", int'(pix_color), int'(ec));
        check(pix_prio == ep, "R2 priority", int'(pix_prio), int'(ep));
        check(pix_transp == et, "R3 transparent", int'(pix_transp), int'(et));
        @(negedge clk);
      end
    end
    for (int k = 0; k < 6; k++) begin
      check(!pix_valid, "R8 no extra pixel", int'(pix_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(!pix_valid && !nt_rd && !pat_rd, "R1 in reset",
          int'({pix_valid, nt_rd, pat_rd}), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!pix_valid && !nt_rd && !pat_rd, "R1 idle after reset",
            int'({pix_valid, nt_rd, pat_rd}), 0);
    end

    // R6 R5 R2: every horizontal offset, including wrap and fine scroll 7
    for (int sx = 0; sx < 512; sx++) begin
      start_line(sx % PH, sx, (sx * 7) % PH);
      collect(sx % PH, sx, (sx * 7) % PH);
    end

    // R7: every vertical offset with wrap
    for (int sy = 0; sy < PH; sy++) begin
      start_line(13, 3 + sy * 16, sy);
      collect(13, 3 + sy * 16, sy);
    end

    // R9: restart while the first line is emitting pixels
    for (int d = 8; d < 20; d += 3) begin
      start_line(1, 500, 2);
      repeat (d) @(negedge clk);
      start_line(9, 37 + d, 30);
      check(!pix_valid, "R9 cleared after restart", int'(pix_valid), 0);
      collect(9, 37 + d, 30);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule